// File: doc/BRIEF.md
# Brown-out Detector Control Logic

This block is the digital side of a supply brown-out monitor. An analog comparator outside the block reports whether the supply is below a selected threshold. The block brings that comparator output into the clock domain, gates it with an enable, and reports it as a live status bit. It keeps a sticky event flag that is set whenever the supply crosses the threshold in either direction. Depending on a mode bit, a brown-out is routed either to an interrupt request or to a reset request for the chip's reset controller.

Software reaches the block through a single 32-bit read/write register port. The detector enable, threshold select, routing mode, low-power mode and low-voltage-reset enable are protected fields. They change only when an external unlock qualifier is high during the write. The event flag is cleared by writing one to it, and needs no unlock. The configuration fields also drive the analog comparator and the low-voltage-reset circuit directly.

Top module: `bod_ctrl`

## Requirements
- R1: After a synchronous reset, the register reads 0x0000_0080: only the low-voltage-reset enable (bit 7) is 1. `bod_irq` and `bod_rst_req` are 0, `det_en` is 0 and `lvr_en` is 1.
- R2: Field layout:
  - bit 0: enable
  - bits [2:1]: threshold select
  - bit 3: routing mode (1 = reset, 0 = interrupt)
  - bit 4: event flag
  - bit 5: low-power mode
  - bit 6: status
  - bit 7: low-voltage-reset enable

  A write with `prot_wr_ok` high loads bits 0, [2:1], 3, 5 and 7. These values read back and appear on `det_en`, `det_vsel`, `det_lpm` and `lvr_en`.
- R3: A write with `prot_wr_ok` low leaves bits 0, [2:1], 3, 5 and 7 unchanged.
- R4: Status (bit 6) is 1 when the synchronised comparator reports the supply below threshold. It goes high at the second rising clock edge after `cmp_async` changes. It reads 0 whenever the enable bit is 0, and writes to it have no effect.
- R5: The event flag (bit 4) is set at the clock edge after any change of the status bit. This covers a downward crossing, an upward crossing, and enabling the detector while the comparator is already high.
- R6: Writing 1 to bit 4 clears the event flag, regardless of `prot_wr_ok`. Writing 0 to bit 4 leaves it unchanged.
- R7: If a status change and a write-one-to-clear of the flag meet in the same cycle, the flag ends up set.
- R8: With enable 1 and routing mode 0, `bod_irq` rises one cycle after status goes high. It stays high after status falls. It drops at the clock edge after the enable bit is seen at 0.
- R9: With routing mode 1, `bod_irq` stays 0. `bod_rst_req` is a single-cycle pulse, high for the cycle after status (with mode 1) first goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_async | input | 1 | Raw comparator output, 1 = supply below threshold |
| reg_wr | input | 1 | Register write strobe |
| prot_wr_ok | input | 1 | Unlock qualifier for the protected fields |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| det_en | output | 1 | Comparator enable |
| det_vsel | output | 2 | Threshold select to the comparator |
| det_lpm | output | 1 | Comparator low-power mode |
| lvr_en | output | 1 | Low-voltage-reset enable |
| bod_irq | output | 1 | Brown-out interrupt request |
| bod_rst_req | output | 1 | Brown-out reset request pulse |

## Verification
A threshold crossing and a software write-one-to-clear of the event flag can land on the same clock edge. The bench provokes this by timing the clear write to the cycle after the status bit changes, which is the cycle in which the crossing is registered. It judges the result by reading the flag back: it must still be 1. A second clear, one cycle later with no crossing, must then bring the flag to 0.

// File: rtl/bod_pkg.sv
// Shared field positions and the configuration record of the brown-out
// control block. Positions are fixed because software decodes them.
package bod_pkg;

    localparam int BIT_EN    = 0;
    localparam int VSEL_LO   = 1;
    localparam int VSEL_W    = 2;
    localparam int BIT_MODE  = 3;
    localparam int BIT_FLAG  = 4;
    localparam int BIT_LPM   = 5;
    localparam int BIT_STAT  = 6;
    localparam int BIT_LVR   = 7;
    localparam int FIELD_TOP = BIT_LVR;

    typedef struct packed {
        logic              lvr_en;
        logic              lpm;
        logic              rst_mode;
        logic [VSEL_W-1:0] vsel;
        logic              en;
    } bod_cfg_t;

endpackage

// File: rtl/bod_sync.sv
// Multi-flop synchroniser for the asynchronous comparator output.
// Assumes STAGES >= 2; the output settles STAGES edges after the input.
module bod_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bod_cfg_regs.sv
// Protected configuration fields. A write only takes effect when the
// external unlock qualifier is high in the same cycle.
module bod_cfg_regs
    import bod_pkg::*;
#(
    parameter bit RST_EN   = 1'b0,
    parameter bit RST_MODE = 1'b0,
    parameter bit RST_LVR  = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  logic     unlock,
    input  bod_cfg_t wr_cfg,
    output bod_cfg_t cfg
);
    localparam bod_cfg_t CFG_RESET = '{
        lvr_en:   RST_LVR,
        lpm:      1'b0,
        rst_mode: RST_MODE,
        vsel:     '0,
        en:       RST_EN
    };

    // Load all protected fields on an unlocked write.
    always_ff @(posedge clk) begin
        if (!rst_n)            cfg <= CFG_RESET;
        else if (wr && unlock) cfg <= wr_cfg;
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && unlock) |=> $stable(cfg)); // R3
endmodule

// File: rtl/bod_event.sv
// Status gating, crossing detection, sticky event flag and routing of a
// brown-out to interrupt or reset. Assumes level_s is already synchronous.
module bod_event (
    input  logic clk,
    input  logic rst_n,
    input  logic level_s,
    input  logic en,
    input  logic rst_mode,
    input  logic clr_req,
    output logic status,
    output logic flag,
    output logic irq,
    output logic rst_req
);
    logic status_q;
    logic crossing;
    logic rcond;
    logic rcond_q;

    assign status   = level_s & en;
    assign crossing = status ^ status_q;
    assign rcond    = status & rst_mode;

    // Remember the previous gated level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= status;
    end

    // Sticky flag: a crossing sets it and beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (crossing) flag <= 1'b1;
        else if (clr_req)  flag <= 1'b0;
    end

    // Interrupt: latch on status in interrupt mode, hold until disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= en & ~rst_mode & (irq | status);
    end

    // Reset request: one-cycle pulse on the rise of status in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcond_q <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rcond_q <= rcond;
            rst_req <= rcond & ~rcond_q;
        end
    end

    AST_FLAG_ON_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (status != status_q) |=> flag); // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((status != status_q) && clr_req) |=> flag); // R7
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq); // R8
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R9
    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req)); // R9
endmodule

// File: rtl/bod_ctrl.sv
// Brown-out detector control: synchronises the comparator, holds the
// protected configuration, and assembles the 32-bit register view.
// Assumes the unlock qualifier comes from an external protection unit.
module bod_ctrl
    import bod_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter bit RST_EN      = 1'b0,
    parameter bit RST_MODE    = 1'b0,
    parameter bit RST_LVR     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_async,
    input  logic              reg_wr,
    input  logic              prot_wr_ok,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              det_en,
    output logic [VSEL_W-1:0] det_vsel,
    output logic              det_lpm,
    output logic              lvr_en,
    output logic              bod_irq,
    output logic              bod_rst_req
);
    localparam int SPARE_LO = FIELD_TOP + 1;

    bod_cfg_t cfg;
    bod_cfg_t wr_cfg;
    logic     level_s;
    logic     status;
    logic     flag;
    logic     clr_req;
    logic     unused_wbits;

    // Pick the protected fields out of the write word.
    always_comb begin
        wr_cfg.en       = reg_wdata[BIT_EN];
        wr_cfg.vsel     = reg_wdata[VSEL_LO +: VSEL_W];
        wr_cfg.rst_mode = reg_wdata[BIT_MODE];
        wr_cfg.lpm      = reg_wdata[BIT_LPM];
        wr_cfg.lvr_en   = reg_wdata[BIT_LVR];
    end

    assign clr_req      = reg_wr & reg_wdata[BIT_FLAG];
    assign unused_wbits = ^{reg_wdata[DATA_W-1:SPARE_LO], reg_wdata[BIT_STAT]};

    bod_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_async),
        .q_sync  (level_s)
    );

    bod_cfg_regs #(
        .RST_EN   (RST_EN),
        .RST_MODE (RST_MODE),
        .RST_LVR  (RST_LVR)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .unlock (prot_wr_ok),
        .wr_cfg (wr_cfg),
        .cfg    (cfg)
    );

    bod_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_s  (level_s),
        .en       (cfg.en),
        .rst_mode (cfg.rst_mode),
        .clr_req  (clr_req),
        .status   (status),
        .flag     (flag),
        .irq      (bod_irq),
        .rst_req  (bod_rst_req)
    );

    // Assemble the register view from configuration and event state.
    always_comb begin
        reg_rdata                       = '0;
        reg_rdata[BIT_EN]               = cfg.en;
        reg_rdata[VSEL_LO +: VSEL_W]    = cfg.vsel;
        reg_rdata[BIT_MODE]             = cfg.rst_mode;
        reg_rdata[BIT_FLAG]             = flag;
        reg_rdata[BIT_LPM]              = cfg.lpm;
        reg_rdata[BIT_STAT]             = status;
        reg_rdata[BIT_LVR]              = cfg.lvr_en;
    end

    assign det_en   = cfg.en;
    assign det_vsel = cfg.vsel;
    assign det_lpm  = cfg.lpm;
    assign lvr_en   = cfg.lvr_en;

    AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |-> !reg_rdata[BIT_STAT]); // R4
endmodule

// File: tb/bod_ctrl_test.sv
module bod_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_async;
    logic        reg_wr;
    logic        prot_wr_ok;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        det_en;
    logic [1:0]  det_vsel;
    logic        det_lpm;
    logic        lvr_en;
    logic        bod_irq;
    logic        bod_rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bod_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmp_async(cmp_async), .reg_wr(reg_wr),
        .prot_wr_ok(prot_wr_ok), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .det_en(det_en), .det_vsel(det_vsel), .det_lpm(det_lpm),
        .lvr_en(lvr_en), .bod_irq(bod_irq), .bod_rst_req(bod_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] data, input logic unlock);
        reg_wr = 1'b1; reg_wdata = data; prot_wr_ok = unlock;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; prot_wr_ok = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 32'h80);
        chk("R1 irq", bod_irq, 0);
        chk("R1 rst_req", bod_rst_req, 0);
        chk("R1 det_en", det_en, 0);
        chk("R1 lvr_en", lvr_en, 1);
    endtask

    task automatic t_protect();
        wr(32'h25, 1'b0);
        chk("R3 locked write ignored", reg_rdata, 32'h80);
        wr(32'h65, 1'b1);   // bit 6 set in data must not stick
        chk("R2 unlocked readback", reg_rdata, 32'h25);
        chk("R4 status write ignored", reg_rdata[6], 0);
        chk("R2 det_en", det_en, 1);
        chk("R2 det_vsel", det_vsel, 2);
        chk("R2 det_lpm", det_lpm, 1);
        chk("R2 lvr_en", lvr_en, 0);
    endtask

    task automatic t_status_irq();
        cmp_async = 1'b1;
        wait_n(1);
        chk("R4 not yet synced", reg_rdata[6], 0);
        wait_n(1);
        chk("R4 status high", reg_rdata, 32'h65);
        chk("R8 irq not yet", bod_irq, 0);
        wait_n(1);
        chk("R5 flag on fall of supply", reg_rdata[4], 1);
        chk("R8 irq raised", bod_irq, 1);
        wr(32'h00, 1'b0);
        chk("R6 write 0 keeps flag", reg_rdata[4], 1);
        wr(32'h10, 1'b0);
        chk("R6 w1c clears flag", reg_rdata, 32'h65);
        cmp_async = 1'b0;
        wait_n(2);
        chk("R4 status low", reg_rdata[6], 0);
        wait_n(1);
        chk("R5 flag on rise of supply", reg_rdata[4], 1);
        chk("R8 irq persists", bod_irq, 1);
        wr(32'h10, 1'b0);
        chk("R6 w1c unlocked not needed", reg_rdata, 32'h25);
    endtask

    task automatic t_set_wins();
        cmp_async = 1'b1;
        wait_n(3);
        wr(32'h10, 1'b0);
        chk("R6 flag cleared", reg_rdata[4], 0);
        cmp_async = 1'b0;
        wait_n(2);
        wr(32'h10, 1'b0);   // clear meets the crossing edge
        chk("R7 set beats clear", reg_rdata[4], 1);
        wr(32'h10, 1'b0);
        chk("R7 later clear works", reg_rdata[4], 0);
    endtask

    task automatic t_disable();
        wr(32'h24, 1'b1);
        chk("R8 irq one more cycle", bod_irq, 1);
        wait_n(1);
        chk("R8 irq dropped", bod_irq, 0);
        cmp_async = 1'b1;
        wait_n(3);
        chk("R4 gated while disabled", reg_rdata[6], 0);
        chk("R5 no flag while disabled", reg_rdata[4], 0);
        wr(32'h25, 1'b1);
        chk("R4 status after enable", reg_rdata[6], 1);
        wait_n(1);
        chk("R5 flag on enable while low supply", reg_rdata[4], 1);
        cmp_async = 1'b0;
        wait_n(3);
        wr(32'h24, 1'b1);
        wr(32'h10, 1'b0);
        chk("R8 irq off after disable", bod_irq, 0);
    endtask

    task automatic t_reset_mode();
        wr(32'h2D, 1'b1);
        chk("R2 mode readback", reg_rdata, 32'h2D);
        cmp_async = 1'b1;
        wait_n(3);
        chk("R9 rst_req pulse", bod_rst_req, 1);
        chk("R9 no irq", bod_irq, 0);
        chk("R5 flag in reset mode", reg_rdata[4], 1);
        wait_n(1);
        chk("R9 pulse single cycle", bod_rst_req, 0);
        wait_n(2);
        chk("R9 no repeat", bod_rst_req, 0);
        chk("R9 irq still low", bod_irq, 0);
    endtask

    initial begin
        rst_n = 1'b0; cmp_async = 1'b0; reg_wr = 1'b0;
        prot_wr_ok = 1'b0; reg_wdata = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_protect();
        t_status_irq();
        t_set_wins();
        t_disable();
        t_reset_mode();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule